// File: doc/BRIEF.md
# Bidirectional Parallel Port Data Register

This block is the data register of an 8-bit printer-style parallel port. A CPU side writes and reads the register with single-cycle strobes. A pad side has a separate output value, an output enable and an input value, so the block can sit in front of a bidirectional pad ring.

A static mode input picks one of two behaviours. In compatibility mode the port only drives: every write goes straight out on the pins, and a read gives back the written value. In extended mode a direction bit, kept in a companion control field, controls the pins. When it selects write, the latched value is driven. When it selects read, the pins are released and reads return the pin values after they pass through a synchronizer. A write always reaches the latch, whatever the direction.

Timing is as follows. A write updates `pad_o` one clock after the strobe. A read strobe loads `rd_data_o` on the next edge, and that value holds until the next read. `pad_oe_o` is combinational in the registered direction bit and the mode input.

Top module: `bidir_pport_data`

## Requirements
- R1: In compatibility mode (`ext_mode_i`=0), a read returns the value of the most recent write.
- R2: In compatibility mode, `pad_oe_o` is 1 and `pad_o` shows the written value on the cycle after the write strobe.
- R3: In extended mode with direction 0 (write), a read returns the latched write data and not the pin values.
- R4: In extended mode with direction 1 (read), a read returns `pad_i` delayed by a two-flop synchronizer. A pin value that has been held for three clocks is returned.
- R5: In extended mode, a write updates the output latch at every direction setting. While the direction is 1, `pad_oe_o` stays 0.
- R6: `pad_oe_o` equals (not `ext_mode_i`) or (direction == 0). It follows a change of the mode input in the same cycle, without waiting for a clock.
- R7: Setting the direction from 1 back to 0 drives the value still held in the latch, without a new write.
- R8: After reset, `pad_o` = 0, `rd_data_o` = 0, and the direction is 0, so `pad_oe_o` = 1.
- R9: In compatibility mode the direction bit has no effect. With direction 1, `pad_oe_o` stays 1 and reads return the latch.
- R10: `rd_data_o` keeps its value while no read strobe occurs, even if a write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Static mode select: 0 compatibility, 1 extended |
| data_wr_i | input | 1 | Data register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_i | input | 1 | Data register read strobe |
| rd_data_o | output | 8 | Read data, loaded on a read strobe |
| dir_wr_i | input | 1 | Direction bit write strobe |
| dir_i | input | 1 | New direction: 0 write (drive), 1 read (release) |
| pad_o | output | 8 | Pad output value |
| pad_oe_o | output | 1 | Pad output enable |
| pad_i | input | 8 | Pad input value |

## Verification
The assertions assume that the mode input only changes while no strobes are active. They also assume that a read strobe and a write strobe never occur in the same cycle, because the property that relates read data to the latch compares against the pre-write value. The bench changes the mode only in idle cycles and issues reads and writes in separate cycles. Before every extended-mode pin read, it holds `pad_i` steady for at least three clocks, so the synchronized value is settled when the read is sampled.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned DATA_W = 8;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= '0;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage
  import pp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             data_wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             dir_wr_i,
  input  logic             dir_i,
  output logic [WIDTH-1:0] latch_o,
  output dir_e             dir_o,
  output logic             oe_o
);
  logic [WIDTH-1:0] latch_q;
  dir_e             dir_q;

  // latch is written in every mode and direction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= '0;
    else if (data_wr_i) latch_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= DIR_WRITE;
    else if (dir_wr_i) dir_q <= dir_e'(dir_i);
  end

  // direction only matters in extended mode
  always_comb oe_o = !ext_mode_i || (dir_q == DIR_WRITE);

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/pp_read_mux.sv
module pp_read_mux
  import pp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  dir_e             dir_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic             sel_pins;
  logic [WIDTH-1:0] rd_src;
  logic [WIDTH-1:0] rd_q;

  always_comb begin
    sel_pins = ext_mode_i && (dir_i == DIR_READ);
    rd_src   = sel_pins ? pins_i : latch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= rd_src;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/bidir_pport_data.sv
module bidir_pport_data
  import pp_pkg::*;
#(
  parameter int unsigned WIDTH       = DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             data_wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             dir_wr_i,
  input  logic             dir_i,
  output logic [WIDTH-1:0] pad_o,
  output logic             pad_oe_o,
  input  logic [WIDTH-1:0] pad_i
);
  logic [WIDTH-1:0] latch_w;
  logic [WIDTH-1:0] pins_sync;
  dir_e             dir_w;

  pp_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .data_wr_i  (data_wr_i),
    .wr_data_i  (wr_data_i),
    .dir_wr_i   (dir_wr_i),
    .dir_i      (dir_i),
    .latch_o    (latch_w),
    .dir_o      (dir_w),
    .oe_o       (pad_oe_o)
  );

  pp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pins_sync)
  );

  pp_read_mux #(.WIDTH(WIDTH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .dir_i      (dir_w),
    .rd_i       (rd_i),
    .latch_i    (latch_w),
    .pins_i     (pins_sync),
    .rd_data_o  (rd_data_o)
  );

  assign pad_o = latch_w;
endmodule

// File: rtl/bidir_pport_data_chk.sv
module bidir_pport_data_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_mode_i,
  input logic             data_wr_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             dir_wr_i,
  input logic             dir_i,
  input logic [WIDTH-1:0] pad_o,
  input logic             pad_oe_o
);
  // mirror of the direction bit, built from the port strobes
  logic dir_mirror;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_mirror <= 1'b0;
    else if (dir_wr_i) dir_mirror <= dir_i;
  end

  AST_COMPAT_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> pad_oe_o); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> pad_o == $past(wr_data_i)); // R5

  AST_EXT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && dir_mirror) |-> !pad_oe_o); // R6

  AST_EXT_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !dir_mirror) |-> pad_oe_o); // R7

  AST_PAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr_i |=> $stable(pad_o)); // R5

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)); // R10

  AST_COMPAT_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !data_wr_i && !ext_mode_i) |=> rd_data_o == $past(pad_o)); // R1

  AST_EXT_WR_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !data_wr_i && ext_mode_i && !dir_mirror) |=> rd_data_o == $past(pad_o)); // R3
endmodule

bind bidir_pport_data bidir_pport_data_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_mode_i (ext_mode_i),
  .data_wr_i  (data_wr_i),
  .wr_data_i  (wr_data_i),
  .rd_i       (rd_i),
  .rd_data_o  (rd_data_o),
  .dir_wr_i   (dir_wr_i),
  .dir_i      (dir_i),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/bidir_pport_data_test.sv
module bidir_pport_data_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd = 1'b0;
  logic [7:0] rd_data;
  logic       dir_wr = 1'b0;
  logic       dir = 1'b0;
  logic [7:0] pad_out;
  logic       pad_oe;
  logic [7:0] pad_in = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_pport_data uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_mode_i (ext_mode),
    .data_wr_i  (data_wr),
    .wr_data_i  (wr_data),
    .rd_i       (rd),
    .rd_data_o  (rd_data),
    .dir_wr_i   (dir_wr),
    .dir_i      (dir),
    .pad_o      (pad_out),
    .pad_oe_o   (pad_oe),
    .pad_i      (pad_in)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; wr_data = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    v = rd_data;
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk); dir_wr = 1'b1; dir = d;
    @(negedge clk); dir_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 pad_o", pad_out, 8'h00);
    chk("R8 rd_data", rd_data, 8'h00);
    chk("R8 oe", {7'b0, pad_oe}, 8'h01);
  endtask

  task automatic t_compat();
    logic [7:0] v;
    ext_mode = 1'b0;
    do_write(8'hA5);
    chk("R2 pad_o", pad_out, 8'hA5);
    chk("R2 oe", {7'b0, pad_oe}, 8'h01);
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R1 read", v, 8'hA5);
    do_write(8'h5A);
    do_read(v);
    chk("R1 read2", v, 8'h5A);
  endtask

  task automatic t_compat_dir_ignored();
    logic [7:0] v;
    set_dir(1'b1);
    chk("R9 oe", {7'b0, pad_oe}, 8'h01);
    pad_in = 8'hF0;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R9 read", v, 8'h5A);
    set_dir(1'b0);
  endtask

  task automatic t_ext_write_dir();
    logic [7:0] v;
    @(negedge clk); ext_mode = 1'b1;
    do_write(8'hC3);
    chk("R3 oe", {7'b0, pad_oe}, 8'h01);
    chk("R3 pad_o", pad_out, 8'hC3);
    pad_in = 8'h11;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R3 read", v, 8'hC3);
  endtask

  task automatic t_ext_read_dir();
    logic [7:0] v;
    set_dir(1'b1);
    chk("R5 oe", {7'b0, pad_oe}, 8'h00);
    pad_in = 8'h96;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R4 pins", v, 8'h96);
    pad_in = 8'h69;
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R4 pins2", v, 8'h69);
    do_write(8'h7E);
    chk("R5 oe after wr", {7'b0, pad_oe}, 8'h00);
    chk("R10 hold on write", rd_data, 8'h69);
    do_read(v);
    chk("R5 read still pins", v, 8'h69);
  endtask

  task automatic t_mode_comb();
    // dir is 1 here: dropping ext_mode raises oe before any edge
    @(negedge clk); ext_mode = 1'b0;
    #1;
    chk("R6 oe comb up", {7'b0, pad_oe}, 8'h01);
    ext_mode = 1'b1;
    #1;
    chk("R6 oe comb down", {7'b0, pad_oe}, 8'h00);
  endtask

  task automatic t_back_to_write();
    logic [7:0] v;
    set_dir(1'b0);
    chk("R7 oe", {7'b0, pad_oe}, 8'h01);
    chk("R7 pad_o", pad_out, 8'h7E);
    do_read(v);
    chk("R7 read latch", v, 8'h7E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compat();
    t_compat_dir_ignored();
    t_ext_write_dir();
    t_ext_read_dir();
    t_mode_comb();
    t_back_to_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule